// File: doc/BRIEF.md
# Flash Status Register Read Controller

This block models the read-mode and status logic of a 16-bit parallel NOR flash interface. It decodes command bytes written over a simple strobe bus. A command is accepted when the write strobe rises while the chip select is low. The block then decides whether a read returns array data from an external input or an eight-bit status snapshot.

The status word is put together from flags reported by a program/erase engine. These are the busy flag, the suspend flags, an error code, a supply fault, a locked-block abort and a buffer-load flag. Error flags are held until software clears them. The snapshot is not live. In asynchronous mode it is taken when the read first becomes enabled. In burst mode it is taken only when chip select or address-valid falls, and then the same word is repeated for every beat of the burst.

All strobes are active low. They are sampled on the system clock `clk`, and the block detects their edges with one register stage.

Top module: `flash_sr_ctrl`

## Requirements
- R1: A command is taken when `we_n` is seen rising while `ce_n` is low. Code 0x70 selects status reads at any address and 0xFF selects array reads. A `we_n` rise with `ce_n` high has no effect.
- R2: Codes 0x40 and 0x10 (word program), 0x20 (block erase) and 0x60 (lock setup) switch reads to status. Status stays selected until 0xFF is written.
- R3: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low, and `dq_out` is zero whenever `dq_oe` is low. In array mode `dq_out` equals `array_data`. In a status read `dq_out[15:8]` is 0x00 and `dq_out[7:0]` is the snapshot.
- R4: With `burst_mode` low, the snapshot is taken at the clock where the first of `ce_n`/`oe_n` is seen falling from both high. It does not change while the read stays enabled.
- R5: With `burst_mode` high, the snapshot is taken only when `ce_n` or `adv_n` is seen falling. Otherwise it holds, whatever the engine flags do, and every beat outputs the same word regardless of `page_addr`.
- R6: In an asynchronous status read, only the word at the `page_addr` latched with the snapshot carries status. Any other page address returns the filler value `FILL` (default 0xFFFF).
- R7: Status bit positions are:
  - bit 7: ready (inverse of `eng_busy`)
  - bit 6: erase suspended
  - bits 5:4: error code (00 ok, 01 program error, 10 erase error, 11 sequence error)
  - bit 3: supply out of range
  - bit 2: program suspended
  - bit 1: locked-block abort
  - bit 0: buffer load in progress
- R8: After reset the snapshot is 0x80, reads return array data and all held error flags are clear.
- R9: Code 0x50 clears bits 5:4, 3 and 1. Bits 7, 6, 2 and 0 keep following the engine. The read mode does not change.
- R10: Error bits are sticky: bits 3 and 1 stay set after the engine drops them. The first nonzero error code is held, and later codes do not replace it until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; command taken on its rise |
| adv_n | input | 1 | Address valid, active low |
| burst_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous/page reads |
| page_addr | input | PAW | Word index within a page |
| cmd_in | input | 8 | Command byte |
| array_data | input | DW | Array word returned in array mode |
| eng_busy | input | 1 | Engine busy |
| eng_erase_susp | input | 1 | Erase suspended |
| eng_prog_susp | input | 1 | Program suspended |
| eng_err_code | input | 2 | Error code reported by the engine |
| eng_vpp_bad | input | 1 | Supply out of range |
| eng_lock_abort | input | 1 | Operation aborted on a locked block |
| eng_buf_load | input | 1 | Buffer load in progress |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Data output enable |

## Verification
The assertions check four things on every cycle:
- the bus output rules: the data bus is quiet when disabled, and the upper byte is zero during a valid status word;
- the mode switch after a read-status command;
- that the burst snapshot holds between `ce_n`/`adv_n` falls;
- that held error codes fall only after a clear command.

Some behaviours need a chosen sequence of stimulus, so only the bench's scenarios show them:
- first-error-wins ordering;
- the filler word on other page addresses;
- the live bits surviving a clear;
- a command ignored while chip select is high;
- a snapshot refreshed by a toggle while the engine changes.

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl #(
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int PAW = 2,
  parameter logic [DW-1:0] FILL = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_n,
  input  logic           oe_n,
  input  logic           we_n,
  input  logic           adv_n,
  input  logic           burst_mode,
  input  logic [PAW-1:0] page_addr,
  input  logic [7:0]     cmd_in,
  input  logic [DW-1:0]  array_data,
  input  logic           eng_busy,
  input  logic           eng_erase_susp,
  input  logic           eng_prog_susp,
  input  logic [1:0]     eng_err_code,
  input  logic           eng_vpp_bad,
  input  logic           eng_lock_abort,
  input  logic           eng_buf_load,
  output logic [DW-1:0]  dq_out,
  output logic           dq_oe
);

  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_PROG_A   = 8'h40;
  localparam logic [7:0] C_PROG_B   = 8'h10;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_LOCK     = 8'h60;
  localparam logic [SW-1:0] SR_RESET = SW'(8'h80);
  localparam int HW = DW - SW;

  logic ce_q, oe_q, we_q, adv_q;
  logic stat_mode;
  logic [SW-1:0] snap;
  logic [PAW-1:0] pg_q;
  logic [1:0] err_code_q;
  logic vpp_q, lock_q;

  logic cmd_evt, clr_cmd, to_stat, to_array;
  logic strb_fall, ce_fall, adv_fall, cap_evt;
  logic [SW-1:0] live;

  assign cmd_evt  = ~we_q & we_n & ~ce_n;
  assign clr_cmd  = cmd_evt && cmd_in == C_CLR_STAT;
  assign to_array = cmd_evt && cmd_in == C_RD_ARRAY;
  assign to_stat  = cmd_evt && (cmd_in == C_RD_STAT || cmd_in == C_PROG_A ||
                    cmd_in == C_PROG_B || cmd_in == C_ERASE || cmd_in == C_LOCK);

  assign strb_fall = (ce_q & oe_q) & ~(ce_n & oe_n);
  assign ce_fall   = ce_q & ~ce_n;
  assign adv_fall  = adv_q & ~adv_n;
  assign cap_evt   = burst_mode ? (ce_fall | adv_fall) : strb_fall;

  assign live = SW'({~eng_busy, eng_erase_susp, err_code_q, vpp_q,
                     eng_prog_susp, lock_q, eng_buf_load});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      oe_q  <= 1'b1;
      we_q  <= 1'b1;
      adv_q <= 1'b1;
    end else begin
      ce_q  <= ce_n;
      oe_q  <= oe_n;
      we_q  <= we_n;
      adv_q <= adv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_mode <= 1'b0;
    else if (to_stat)  stat_mode <= 1'b1;
    else if (to_array) stat_mode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code_q <= 2'b00;
      vpp_q      <= 1'b0;
      lock_q     <= 1'b0;
    end else if (clr_cmd) begin
      err_code_q <= 2'b00;
      vpp_q      <= 1'b0;
      lock_q     <= 1'b0;
    end else begin
      if (err_code_q == 2'b00) err_code_q <= eng_err_code;
      vpp_q  <= vpp_q | eng_vpp_bad;
      lock_q <= lock_q | eng_lock_abort;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= SR_RESET;
      pg_q <= '0;
    end else if (cap_evt) begin
      snap <= live;
      pg_q <= page_addr;
    end
  end

  logic [DW-1:0] stat_word;
  assign stat_word = {{HW{1'b0}}, snap};
  assign dq_oe = ~ce_n & ~oe_n;

  always_comb begin
    dq_out = '0;
    if (dq_oe) begin
      if (!stat_mode)                         dq_out = array_data;
      else if (burst_mode || page_addr == pg_q) dq_out = stat_word;
      else                                    dq_out = FILL;
    end
  end

endmodule

// File: rtl/flash_sr_ctrl_chk.sv
module flash_sr_ctrl_chk #(
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int PAW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce_n,
  input logic           oe_n,
  input logic           we_n,
  input logic           adv_n,
  input logic           burst_mode,
  input logic [PAW-1:0] page_addr,
  input logic [7:0]     cmd_in,
  input logic [DW-1:0]  dq_out,
  input logic           dq_oe,
  input logic           stat_mode,
  input logic [SW-1:0]  snap,
  input logic [PAW-1:0] pg_q,
  input logic [1:0]     err_code_q
);

  AST_RESET_SNAP: assert property (@(posedge clk) !rst_n |-> (snap == SW'(8'h80) && !stat_mode)); // R8

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && stat_mode && (burst_mode || page_addr == pg_q)) |-> dq_out[DW-1:SW] == '0); // R3

  AST_STAT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!we_n) && we_n && !ce_n && cmd_in == 8'h70) |=> stat_mode); // R1

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && !($past(ce_n) && !ce_n) && !($past(adv_n) && !adv_n)) |=> $stable(snap)); // R5

  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_code_q) != 2'b00 && err_code_q == 2'b00) |->
      ($past(!we_n, 2) && $past(we_n) && $past(!ce_n) && $past(cmd_in) == 8'h50)); // R10

endmodule

bind flash_sr_ctrl flash_sr_ctrl_chk #(.DW(DW), .SW(SW), .PAW(PAW)) u_chk (.*);

// File: tb/test_flash_sr_ctrl.sv
module test_flash_sr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1, burst_mode = 1'b0;
  logic [1:0] page_addr = '0;
  logic [7:0] cmd_in = '0;
  logic [15:0] array_data = 16'hA5C3;
  logic eng_busy = 0, eng_erase_susp = 0, eng_prog_susp = 0, eng_vpp_bad = 0;
  logic eng_lock_abort = 0, eng_buf_load = 0;
  logic [1:0] eng_err_code = 2'b00;
  logic [15:0] dq_out;
  logic dq_oe;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_sr_ctrl i_flash_sr_ctrl (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_cmd(logic [7:0] c, logic cen = 1'b0);
    @(negedge clk); ce_n = cen; we_n = 0; cmd_in = c;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
  endtask

  task automatic rd_async(string tag, logic [15:0] exp);
    @(negedge clk); ce_n = 0; oe_n = 0; page_addr = 2'd0;
    @(negedge clk); @(negedge clk);
    chk(tag, dq_out, exp);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 idle bus", {dq_oe, dq_out[14:0]}, 16'h0000);
    rd_async("R8 array after reset", 16'hA5C3);
    wr_cmd(8'h70);
    rd_async("R8 R7 reset status", 16'h0080);
  endtask

  task automatic t_modes();
    wr_cmd(8'hFF);
    rd_async("R1 read array", 16'hA5C3);
    wr_cmd(8'h70, 1'b1);
    rd_async("R1 cmd ignored ce high", 16'hA5C3);
    wr_cmd(8'h20);
    rd_async("R2 erase -> status", 16'h0080);
    wr_cmd(8'h40);
    rd_async("R2 program -> status", 16'h0080);
    wr_cmd(8'hFF);
    wr_cmd(8'h60);
    rd_async("R2 lock -> status", 16'h0080);
    wr_cmd(8'hFF);
  endtask

  task automatic t_bits();
    wr_cmd(8'h70);
    @(negedge clk); eng_busy = 1; eng_erase_susp = 1; eng_prog_susp = 1; eng_buf_load = 1;
    rd_async("R7 live bits", 16'h0045);
    @(negedge clk); eng_busy = 0; eng_erase_susp = 0; eng_prog_susp = 0; eng_buf_load = 0;
    rd_async("R7 ready again", 16'h0080);
  endtask

  task automatic t_sticky();
    @(negedge clk); eng_err_code = 2'b01; eng_vpp_bad = 1; eng_lock_abort = 1;
    @(negedge clk); eng_err_code = 2'b00; eng_vpp_bad = 0; eng_lock_abort = 0;
    rd_async("R10 errors held", 16'h009A);
    @(negedge clk); eng_err_code = 2'b10;
    @(negedge clk); eng_err_code = 2'b00;
    rd_async("R10 first error wins", 16'h009A);
    @(negedge clk); eng_erase_susp = 1; eng_buf_load = 1;
    wr_cmd(8'h50);
    rd_async("R9 clear keeps live bits", 16'h00C1);
    @(negedge clk); eng_erase_susp = 0; eng_buf_load = 0;
    @(negedge clk); eng_err_code = 2'b11;
    @(negedge clk); eng_err_code = 2'b00;
    rd_async("R7 sequence error code", 16'h00B0);
    wr_cmd(8'h50);
    rd_async("R9 cleared", 16'h0080);
  endtask

  task automatic t_async_edge();
    @(negedge clk); oe_n = 0; page_addr = 2'd2;
    @(negedge clk); eng_busy = 1;
    @(negedge clk); ce_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R4 latched on first fall", dq_out, 16'h0080);
    chk("R6 first page word", dq_out, 16'h0080);
    page_addr = 2'd3;
    @(negedge clk);
    chk("R6 other page word filler", dq_out, 16'hFFFF);
    ce_n = 1; oe_n = 1; eng_busy = 0;
    @(negedge clk);
  endtask

  task automatic t_burst();
    @(negedge clk); burst_mode = 1; ce_n = 0; oe_n = 0; adv_n = 0;
    @(negedge clk); adv_n = 1;
    @(negedge clk); eng_busy = 1; eng_prog_susp = 1;
    for (int i = 0; i < 4; i++) begin
      page_addr = 2'(i);
      @(negedge clk);
      chk("R5 burst word repeated", dq_out, 16'h0080);
    end
    adv_n = 0;
    @(negedge clk); adv_n = 1;
    @(negedge clk);
    chk("R5 adv toggle refresh", dq_out, 16'h0004);
    chk("R3 upper byte zero", {8'h00, dq_out[15:8]}, 16'h0000);
    ce_n = 1; oe_n = 1; burst_mode = 0; eng_busy = 0; eng_prog_susp = 0;
    @(negedge clk);
    wr_cmd(8'hFF);
    rd_async("R3 array passthrough", 16'hA5C3);
  endtask

  initial begin
    #1 rst_n = 0;
    #10 rst_n = 1;
    t_reset();
    t_modes();
    t_bits();
    t_sticky();
    t_async_edge();
    t_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule